// File: doc/BRIEF.md
# ADC Regular-Conversion Mode Controller

This block holds the mode configuration that governs how an analog-to-digital converter runs its regular conversions. The modes are one-shot, repeating and chopped-sequence conversion, a wait-for-read delay enable, a policy for results that arrive before the previous one was read, and two injected-group bits that constrain the regular modes. Software writes the mode word through a small register port. A write that would change a field belonging to a conversion group that is running is refused. A write that would produce an illegal combination of modes is also refused. Either refusal leaves the stored word untouched and raises an error pulse.

The block also keeps the regular and injected run flags, latches results from a converter stub into a data register, and raises a sticky overrun flag. When two converters work as a pair, the instance built as the follower takes its repeat, chopped and delay bits from the leader whenever the pairing select is nonzero. It then ignores its own writes to those fields.

Top module: `adc_regmode_ctrl`

## Requirements
- R1: After reset, the mode word, the data register, the overrun flag and both run flags read 0, and `wr_err` is low.
- R2: The mode word at address 0 has these fields: bit 0 repeat (continuous), bit 1 chopped (discontinuous), bit 2 delay, bit 3 overwrite policy, bit 4 injected chopped, bit 5 injected auto. Address 1 bit 0 is the overrun flag. Address 2 holds the data register. A write that is accepted reads back unchanged.
- R3: A mode write whose result would have bit 0 and bit 1 both set is refused.
- R4: A mode write whose result would have bit 5 set together with bit 1 or bit 4 is refused.
- R5: While the regular run flag is 1, a write that changes bit 0, 1 or 3 is refused. A write that leaves those bits equal is accepted.
- R6: A write that changes bit 2 is refused while either run flag is 1. A write that changes bit 4 or 5 is refused while the injected run flag is 1.
- R7: In a follower instance with `dual_sel` nonzero, bits 0, 1 and 2 read and drive out the leader's bits. Written values for those bits are ignored, and the other bits stay writable. With `dual_sel` zero, the instance's own stored bits return.
- R8: With bit 3 at 0, a result that arrives while the previous one is still unread leaves the data register unchanged.
- R9: With bit 3 at 1, such a result replaces the data register. In both policies the overrun flag sets and stays set until a write of 1 to address 1 bit 0.
- R10: A refused write raises `wr_err` for exactly the one cycle after the write. An accepted write leaves it low.
- R11: `reg_start` sets the regular run flag. With bit 0 at 0, a result marked last clears the flag. With bit 0 at 1, the flag stays set until `reg_stop`.
- R12: `inj_start` sets the injected run flag and `inj_done` clears it.
- R13: `dr_rd` marks the data register read. A result that arrives in the same cycle as `dr_rd` loads the register and is not an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (0 mode, 1 status, 2 data) |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data for `cfg_addr` |
| wr_err | output | 1 | One-cycle pulse after a refused mode write |
| dual_sel | input | DUAL_W | Pairing select; nonzero turns on mirroring in a follower |
| lead_cont | input | 1 | Leader repeat bit (used by a follower) |
| lead_disc | input | 1 | Leader chopped bit (used by a follower) |
| lead_dly | input | 1 | Leader delay bit (used by a follower) |
| mode_cont | output | 1 | Effective repeat bit |
| mode_disc | output | 1 | Effective chopped bit |
| mode_dly | output | 1 | Effective delay bit |
| mode_ovw | output | 1 | Overwrite policy bit |
| reg_start | input | 1 | Start request for regular conversions |
| reg_stop | input | 1 | Stop request for regular conversions |
| inj_start | input | 1 | Start request for injected conversions |
| inj_done | input | 1 | Injected sequence finished |
| reg_busy | output | 1 | Regular run flag |
| inj_busy | output | 1 | Injected run flag |
| res_valid | input | 1 | Converter result valid |
| res_last | input | 1 | Result ends the regular sequence |
| res_data | input | DATA_W | Converter result |
| dr_rd | input | 1 | Data register read strobe |
| dr_out | output | DATA_W | Data register |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Most faults in the stored mode word show up on the next read of address 0 or on `wr_err` one cycle after the offending write. A wrong lock or forbidden-combination decision is therefore seen within two cycles. A lost or stuck unread marker appears at the second result: `dr_out` holds or changes against the policy, and `ovr_flag` disagrees one cycle after that result. Faults in the run flags show on `reg_busy` or `inj_busy` one cycle after the start, last-result, stop or done input. Mirroring faults are seen at once on the follower's read data when `dual_sel` changes.

// File: rtl/adc_rm_pkg.sv
package adc_rm_pkg;

  typedef struct packed {
    logic inj_auto;
    logic inj_disc;
    logic ovw;
    logic dly;
    logic disc;
    logic cont;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam int ADR_MODE = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_DATA = 2;

endpackage

// File: rtl/adc_mode_regs.sv
module adc_mode_regs
  import adc_rm_pkg::*;
#(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  mode_t wr_mode,
  input  logic  reg_busy,
  input  logic  inj_busy,
  input  logic  dual_on,
  input  logic  lead_cont,
  input  logic  lead_disc,
  input  logic  lead_dly,
  output mode_t eff_mode,
  output logic  wr_err
);

  mode_t mode_q, mode_d;
  mode_t cand, cand_eff;
  logic  mirror;
  logic  lock_viol, forbid, accept;
  logic  err_d, err_q;

  generate
    if (IS_SLAVE) begin : g_follow
      assign mirror = dual_on;
    end else begin : g_lead
      logic unused_lead;
      assign unused_lead = ^{lead_cont, lead_disc, lead_dly, dual_on};
      assign mirror = 1'b0;
    end
  endgenerate

  always_comb begin
    eff_mode = mode_q;
    if (mirror) begin
      eff_mode.cont = lead_cont;
      eff_mode.disc = lead_disc;
      eff_mode.dly  = lead_dly;
    end
  end

  always_comb begin
    cand          = mode_q;
    cand.ovw      = wr_mode.ovw;
    cand.inj_disc = wr_mode.inj_disc;
    cand.inj_auto = wr_mode.inj_auto;
    if (!mirror) begin
      cand.cont = wr_mode.cont;
      cand.disc = wr_mode.disc;
      cand.dly  = wr_mode.dly;
    end
    cand_eff = cand;
    if (mirror) begin
      cand_eff.cont = lead_cont;
      cand_eff.disc = lead_disc;
      cand_eff.dly  = lead_dly;
    end
  end

  always_comb begin
    lock_viol = 1'b0;
    if (reg_busy && ((cand_eff.cont != eff_mode.cont) ||
                     (cand_eff.disc != eff_mode.disc) ||
                     (cand_eff.ovw  != eff_mode.ovw)))
      lock_viol = 1'b1;
    if ((reg_busy || inj_busy) && (cand_eff.dly != eff_mode.dly))
      lock_viol = 1'b1;
    if (inj_busy && ((cand_eff.inj_disc != eff_mode.inj_disc) ||
                     (cand_eff.inj_auto != eff_mode.inj_auto)))
      lock_viol = 1'b1;
    forbid = (cand_eff.disc && cand_eff.cont) ||
             (cand_eff.inj_auto && (cand_eff.disc || cand_eff.inj_disc));
    accept = wr_en && !lock_viol && !forbid;
    err_d  = wr_en && !accept;
    mode_d = accept ? cand : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign wr_err = err_q;

endmodule

// File: rtl/adc_run_flags.sv
module adc_run_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_start,
  input  logic reg_stop,
  input  logic seq_end,
  input  logic cont_on,
  input  logic inj_start,
  input  logic inj_done,
  output logic reg_busy,
  output logic inj_busy
);

  logic rb_q, rb_d, ib_q, ib_d;

  always_comb begin
    rb_d = rb_q;
    if (reg_start)
      rb_d = 1'b1;
    else if (reg_stop || (seq_end && !cont_on))
      rb_d = 1'b0;
    ib_d = ib_q;
    if (inj_start)
      ib_d = 1'b1;
    else if (inj_done)
      ib_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= 1'b0;
      ib_q <= 1'b0;
    end else begin
      rb_q <= rb_d;
      ib_q <= ib_d;
    end
  end

  assign reg_busy = rb_q;
  assign inj_busy = ib_q;

endmodule

// File: rtl/adc_data_path.sv
module adc_data_path #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              dr_rd,
  input  logic              ovw,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] dout,
  output logic              pend,
  output logic              ovr
);

  logic [DATA_W-1:0] dr_q, dr_d;
  logic pend_q, pend_d, ovr_q, ovr_d;
  logic ovr_evt, load_en;

  always_comb begin
    ovr_evt = res_valid && pend_q && !dr_rd;
    load_en = res_valid && (!ovr_evt || ovw);
    dr_d    = load_en ? res_data : dr_q;
    pend_d  = pend_q;
    if (res_valid)
      pend_d = 1'b1;
    else if (dr_rd)
      pend_d = 1'b0;
    ovr_d = ovr_q;
    if (ovr_evt)
      ovr_d = 1'b1;
    else if (ovr_clr)
      ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load_en)
        dr_q <= dr_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign dout = dr_q;
  assign pend = pend_q;
  assign ovr  = ovr_q;

endmodule

// File: rtl/adc_regmode_ctrl.sv
module adc_regmode_ctrl
  import adc_rm_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CFG_W    = 16,
  parameter int ADDR_W   = 2,
  parameter int DUAL_W   = 2,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              wr_err,
  input  logic [DUAL_W-1:0] dual_sel,
  input  logic              lead_cont,
  input  logic              lead_disc,
  input  logic              lead_dly,
  output logic              mode_cont,
  output logic              mode_disc,
  output logic              mode_dly,
  output logic              mode_ovw,
  input  logic              reg_start,
  input  logic              reg_stop,
  input  logic              inj_start,
  input  logic              inj_done,
  output logic              reg_busy,
  output logic              inj_busy,
  input  logic              res_valid,
  input  logic              res_last,
  input  logic [DATA_W-1:0] res_data,
  input  logic              dr_rd,
  output logic [DATA_W-1:0] dr_out,
  output logic              ovr_flag
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync;
  logic              rst_int_n;
  mode_t             eff_mode;
  logic              mode_wr, stat_wr, ovr_clr;
  logic              data_pend;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= '0;
    else
      rst_sync <= {rst_sync[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_W-1];

  assign mode_wr      = cfg_we && (cfg_addr == ADDR_W'(ADR_MODE));
  assign stat_wr      = cfg_we && (cfg_addr == ADDR_W'(ADR_STAT));
  assign ovr_clr      = stat_wr && cfg_wdata[0];
  assign unused_wdata = ^cfg_wdata[CFG_W-1:MODE_W];

  adc_mode_regs #(.IS_SLAVE(IS_SLAVE)) u_mode (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (mode_wr),
    .wr_mode  (mode_t'(cfg_wdata[MODE_W-1:0])),
    .reg_busy (reg_busy),
    .inj_busy (inj_busy),
    .dual_on  (|dual_sel),
    .lead_cont(lead_cont),
    .lead_disc(lead_disc),
    .lead_dly (lead_dly),
    .eff_mode (eff_mode),
    .wr_err   (wr_err)
  );

  adc_run_flags u_run (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .reg_start(reg_start),
    .reg_stop (reg_stop),
    .seq_end  (res_valid && res_last),
    .cont_on  (eff_mode.cont),
    .inj_start(inj_start),
    .inj_done (inj_done),
    .reg_busy (reg_busy),
    .inj_busy (inj_busy)
  );

  adc_data_path #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .res_valid(res_valid),
    .res_data (res_data),
    .dr_rd    (dr_rd),
    .ovw      (eff_mode.ovw),
    .ovr_clr  (ovr_clr),
    .dout     (dr_out),
    .pend     (data_pend),
    .ovr      (ovr_flag)
  );

  assign mode_cont = eff_mode.cont;
  assign mode_disc = eff_mode.disc;
  assign mode_dly  = eff_mode.dly;
  assign mode_ovw  = eff_mode.ovw;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_W'(ADR_MODE): cfg_rdata[MODE_W-1:0] = eff_mode;
      ADDR_W'(ADR_STAT): cfg_rdata[0]          = ovr_flag;
      ADDR_W'(ADR_DATA): cfg_rdata[DATA_W-1:0] = dr_out;
      default:           cfg_rdata             = '0;
    endcase
  end

endmodule

// File: rtl/adc_regmode_ctrl_chk.sv
module adc_regmode_ctrl_chk #(
  parameter int DATA_W   = 12,
  parameter bit IS_SLAVE = 1'b0
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              cfg_we,
  input logic              reg_start,
  input logic              reg_busy,
  input logic              res_valid,
  input logic              res_last,
  input logic              dr_rd,
  input logic              data_pend,
  input logic              mode_cont,
  input logic              mode_disc,
  input logic              mode_ovw,
  input logic [DATA_W-1:0] dr_out,
  input logic              ovr_flag,
  input logic              wr_err
);

  a_r3_no_disc_cont: assert property (@(posedge clk) disable iff (!rst_int_n)
    (IS_SLAVE == 1'b0) |-> !(mode_disc && mode_cont));

  a_r5_bits_locked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_busy && IS_SLAVE == 1'b0) |=> ($stable(mode_cont) && $stable(mode_disc)));

  a_r5_ovw_locked: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_busy |=> $stable(mode_ovw));

  a_r8_keep_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid && data_pend && !dr_rd && !mode_ovw) |=> $stable(dr_out));

  a_r9_ovr_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid && data_pend && !dr_rd) |=> ovr_flag);

  a_r10_err_after_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_err |-> $past(cfg_we));

  a_r11_single_ends: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_busy && res_valid && res_last && !mode_cont && !reg_start) |=> !reg_busy);

endmodule

bind adc_regmode_ctrl adc_regmode_ctrl_chk #(.DATA_W(DATA_W), .IS_SLAVE(IS_SLAVE)) chk_i (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .cfg_we   (cfg_we),
  .reg_start(reg_start),
  .reg_busy (reg_busy),
  .res_valid(res_valid),
  .res_last (res_last),
  .dr_rd    (dr_rd),
  .data_pend(data_pend),
  .mode_cont(mode_cont),
  .mode_disc(mode_disc),
  .mode_ovw (mode_ovw),
  .dr_out   (dr_out),
  .ovr_flag (ovr_flag),
  .wr_err   (wr_err)
);

// File: tb/adc_regmode_ctrl_tb_top.sv
module adc_regmode_ctrl_tb_top;

  localparam int DATA_W = 12;
  localparam int CFG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int DUAL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cfg_we = 1'b0, s_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CFG_W-1:0]  cfg_wdata = '0;
  logic [CFG_W-1:0]  cfg_rdata, s_rdata;
  logic              wr_err, s_err;
  logic [DUAL_W-1:0] s_dual = '0;
  logic              m_cont, m_disc, m_dly, m_ovw;
  logic              s_cont, s_disc, s_dly, s_ovw;
  logic              reg_start = 1'b0, reg_stop = 1'b0, inj_start = 1'b0, inj_done = 1'b0;
  logic              reg_busy, inj_busy, s_rbusy, s_ibusy;
  logic              res_valid = 1'b0, res_last = 1'b0, dr_rd = 1'b0;
  logic [DATA_W-1:0] res_data = '0;
  logic [DATA_W-1:0] dr_out, s_dout;
  logic              ovr_flag, s_ovr;

  adc_regmode_ctrl #(.DATA_W(DATA_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W),
                     .DUAL_W(DUAL_W), .IS_SLAVE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_err(wr_err),
    .dual_sel('0), .lead_cont(1'b0), .lead_disc(1'b0), .lead_dly(1'b0),
    .mode_cont(m_cont), .mode_disc(m_disc), .mode_dly(m_dly), .mode_ovw(m_ovw),
    .reg_start(reg_start), .reg_stop(reg_stop), .inj_start(inj_start),
    .inj_done(inj_done), .reg_busy(reg_busy), .inj_busy(inj_busy),
    .res_valid(res_valid), .res_last(res_last), .res_data(res_data),
    .dr_rd(dr_rd), .dr_out(dr_out), .ovr_flag(ovr_flag)
  );

  adc_regmode_ctrl #(.DATA_W(DATA_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W),
                     .DUAL_W(DUAL_W), .IS_SLAVE(1'b1)) slave_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(s_rdata), .wr_err(s_err),
    .dual_sel(s_dual), .lead_cont(m_cont), .lead_disc(m_disc), .lead_dly(m_dly),
    .mode_cont(s_cont), .mode_disc(s_disc), .mode_dly(s_dly), .mode_ovw(s_ovw),
    .reg_start(1'b0), .reg_stop(1'b0), .inj_start(1'b0), .inj_done(1'b0),
    .reg_busy(s_rbusy), .inj_busy(s_ibusy),
    .res_valid(1'b0), .res_last(1'b0), .res_data('0),
    .dr_rd(1'b0), .dr_out(s_dout), .ovr_flag(s_ovr)
  );

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return 32'(cfg_rdata);
      1: return 32'(dr_out);
      2: return 32'(ovr_flag);
      3: return 32'(wr_err);
      4: return 32'(reg_busy);
      5: return 32'(inj_busy);
      6: return 32'(s_rdata);
      7: return 32'(s_err);
      8: return 32'({s_dly, s_disc, s_cont});
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  // Monitor: compares queued expectations 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = observe(it.kind);
        n_vec++;
        if (act !== it.val) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
        end
      end
    end
  end

  task automatic expect_item(int kind, logic [31:0] val, string req);
    item_t it;
    it.kind = kind;
    it.val  = val;
    it.req  = req;
    q.push_back(it);
  endtask

  task automatic adv();
    @(negedge clk);
    cfg_we = 1'b0; s_we = 1'b0;
    reg_start = 1'b0; reg_stop = 1'b0; inj_start = 1'b0; inj_done = 1'b0;
    res_valid = 1'b0; res_last = 1'b0; dr_rd = 1'b0;
  endtask

  task automatic wr(int a, logic [15:0] d, logic e, string r);
    cfg_addr = ADDR_W'(a); cfg_wdata = d; cfg_we = 1'b1;
    expect_item(3, 32'(e), r);
    adv();
  endtask

  task automatic swr(int a, logic [15:0] d, logic e, string r);
    cfg_addr = ADDR_W'(a); cfg_wdata = d; s_we = 1'b1;
    expect_item(7, 32'(e), r);
    adv();
  endtask

  task automatic rd(int a, logic [31:0] v, string r);
    cfg_addr = ADDR_W'(a);
    expect_item(0, v, r);
    expect_item(3, 32'd0, "R10 single-cycle error");
    adv();
  endtask

  task automatic srd(int a, logic [31:0] v, string r);
    cfg_addr = ADDR_W'(a);
    expect_item(6, v, r);
    adv();
  endtask

  task automatic result(logic [DATA_W-1:0] d, logic last, logic rd_now,
                        logic [31:0] exp_d, logic exp_o, string r);
    res_valid = 1'b1; res_data = d; res_last = last; dr_rd = rd_now;
    expect_item(1, exp_d, r);
    adv();
    expect_item(2, 32'(exp_o), r);
    adv();
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 5000 && !done; wd++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    expect_item(4, 0, "R1 reg_busy"); expect_item(5, 0, "R1 inj_busy");
    expect_item(2, 0, "R1 ovr"); expect_item(1, 0, "R1 data");
    rd(0, 32'h0, "R1 mode");
    rd(2, 32'h0, "R1 data reg");

    // R2 field layout and read-back
    wr(0, 16'h0001, 1'b0, "R2 write repeat");
    rd(0, 32'h01, "R2 readback");
    // R3 forbidden repeat+chopped
    wr(0, 16'h0003, 1'b1, "R3 reject both");
    rd(0, 32'h01, "R3 unchanged");
    wr(0, 16'h000A, 1'b0, "R2 chopped+overwrite");
    rd(0, 32'h0A, "R2 readback 0A");
    // R4 injected auto rules
    wr(0, 16'h0022, 1'b1, "R4 auto with chopped");
    wr(0, 16'h0030, 1'b1, "R4 auto with inj chopped");
    rd(0, 32'h0A, "R4 unchanged");
    wr(0, 16'h0028, 1'b0, "R4 auto alone ok");
    rd(0, 32'h28, "R4 readback");

    // R11 start regular, R5/R6 locks
    reg_start = 1'b1; expect_item(4, 1, "R11 start sets busy"); adv();
    wr(0, 16'h0020, 1'b1, "R5 policy locked");
    wr(0, 16'h002C, 1'b1, "R6 delay locked by regular");
    wr(0, 16'h0028, 1'b0, "R5 same value accepted");
    rd(0, 32'h28, "R5 unchanged");

    // R9 overwrite policy, R13 read marker
    result(12'h123, 1'b0, 1'b0, 32'h123, 1'b0, "R9 first result");
    result(12'h456, 1'b0, 1'b0, 32'h456, 1'b1, "R9 overwrite on overrun");
    rd(1, 32'h1, "R9 status flag");
    wr(1, 16'h0001, 1'b0, "R9 clear write");
    expect_item(2, 0, "R9 flag cleared"); rd(1, 32'h0, "R9 status cleared");
    dr_rd = 1'b1; adv();
    result(12'h789, 1'b1, 1'b0, 32'h789, 1'b0, "R13 after read no overrun");
    expect_item(4, 0, "R11 last ends single"); adv();

    // R8 keep policy
    wr(0, 16'h0000, 1'b0, "R8 clear modes");
    result(12'hAAA, 1'b0, 1'b0, 32'h789, 1'b1, "R8 data kept");
    rd(2, 32'h789, "R8 data reg via port");
    wr(1, 16'h0001, 1'b0, "R9 clear again");
    result(12'hBBB, 1'b0, 1'b1, 32'hBBB, 1'b0, "R13 same-cycle read");

    // R12 injected flag, R6 locks
    inj_start = 1'b1; expect_item(5, 1, "R12 inj start"); adv();
    wr(0, 16'h0004, 1'b1, "R6 delay locked by injected");
    wr(0, 16'h0010, 1'b1, "R6 inj chopped locked");
    rd(0, 32'h0, "R6 unchanged");
    inj_done = 1'b1; expect_item(5, 0, "R12 inj done"); adv();
    wr(0, 16'h0004, 1'b0, "R6 delay writable when idle");
    rd(0, 32'h04, "R6 readback");

    // R11 continuous mode
    wr(0, 16'h0005, 1'b0, "R11 repeat+delay");
    reg_start = 1'b1; adv();
    res_valid = 1'b1; res_last = 1'b1; res_data = 12'h321; dr_rd = 1'b1;
    expect_item(4, 1, "R11 repeat keeps busy"); adv();
    reg_stop = 1'b1; expect_item(4, 0, "R11 stop clears"); adv();

    // R7 follower mirroring (leader mode is 0x05)
    srd(0, 32'h00, "R7 follower own bits");
    s_dual = 2'b01;
    expect_item(8, 32'h5, "R7 mirrored outputs");
    srd(0, 32'h05, "R7 mirrored read");
    swr(0, 16'h0008, 1'b0, "R7 policy writable");
    srd(0, 32'h0D, "R7 mirrored fields ignored");
    swr(0, 16'h0002, 1'b0, "R7 chopped write ignored");
    srd(0, 32'h05, "R7 after ignored write");
    s_dual = 2'b00;
    srd(0, 32'h00, "R7 own bits return");

    adv();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule